// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Selectable Pin Drive

This block gathers condition events from three functional groups (a primary group with one status register, a framer group with several status registers, and a data-link group with one status register) and merges them onto a single interrupt pin. Each status register holds sticky bits that are set by event pulses. Each status register also has a per-bit enable mask, and a small global mask enables each group as a whole. A status bit raises the interrupt only when both its own enable and its group's enable are set.

Software drains the conditions through a simple read port. It gives an address and a one-cycle read strobe. The addressed status byte comes back on the following cycle, and that register is cleared in the same step. A two-bit mode input selects the asserted level of the pin and whether the idle state is actively driven or released. Releasing the idle state lets several devices share one line as a wired-OR (active-high) or wired-AND (active-low) net. The block produces the pin value and an output-enable, and an external pad does the actual three-state drive.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every status register reads as zero, `rd_data_o` is 0, `irq_pin_o` is 0 and `irq_oe_o` is 1.
- R2: A 1 on any bit of `evt_i[s*8 +: 8]` sets the matching bit of status register `s`. The bit stays set, whatever later events do, until a read of address `s` clears it.
- R3: A read strobe with address `s` below the source count returns status register `s` (its value before the clear) on `rd_data_o` one cycle later. It clears only that register. With no strobe, `rd_data_o` is 0.
- R4: When an event bit and a read of the same register fall in the same cycle, the event wins. That bit is set after the read, while the returned data shows the value from before the read.
- R5: The interrupt is active only when some status bit and its enable bit are both 1 and the group enable for that source is also 1. Source 0 uses `blk_en_i[0]`, sources 1 to FRM_REGS use `blk_en_i[1]`, and source FRM_REGS+1 uses `blk_en_i[2]`.
- R6: `irq_pin_o` and `irq_oe_o` follow a change of status, enables or mode one clock later.
- R7: With `mode_low_i`=0 and the interrupt active, pin=1 and oe=1. With `mode_low_i`=1 and the interrupt active, pin=0 and oe=1. When the interrupt is inactive, the pin shows the idle level (equal to `mode_low_i`), and oe=0 if `mode_release_i`=1, otherwise oe=1.
- R8: A read at an address equal to or above the source count returns 0 and clears no register.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_SRC*DATA_W | Condition event pulses; byte s belongs to status register s |
| bit_en_i | input | NUM_SRC*DATA_W | Per-bit interrupt enables, same layout as `evt_i` |
| blk_en_i | input | 3 | Group enables: 0 primary, 1 framer, 2 data link |
| mode_release_i | input | 1 | 1 releases the pin (oe=0) while the interrupt is idle |
| mode_low_i | input | 1 | 1 makes the asserted level low |
| rd_stb_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Status register address |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the strobe |
| irq_pin_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
The checker takes the read strobe, address and mode inputs to be synchronous to `clk` and steady over each clock period. It also takes the event inputs to be pulses, meaning any bit held high simply re-sets its status bit every cycle. The bench drives every input only on the falling edge. It sends random events, enables, modes and reads, including addresses past the last register. A behavioural reference is compared against the pin, the output-enable and the read data on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    GRP_PRIMARY = 2'd0,
    GRP_FRAMER  = 2'd1,
    GRP_LINK    = 2'd2
  } grp_e;

  localparam int unsigned NUM_GRP = 3;

  // Group that owns source index s when the framer has nfrm registers.
  function automatic int unsigned grp_of(input int unsigned s, input int unsigned nfrm);
    if (s == 0)
      return int'(GRP_PRIMARY);
    else if (s <= nfrm)
      return int'(GRP_FRAMER);
    else
      return int'(GRP_LINK);
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC*DATA_W-1:0]   evt_i,
  input  logic                        rd_stb_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [NUM_SRC*DATA_W-1:0]   status_o,
  output logic [DATA_W-1:0]           rd_data_o
);

  logic [DATA_W-1:0] sel_data;

  // Sticky status registers, one per source.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic              hit;
    logic [DATA_W-1:0] st_q;

    assign hit = rd_stb_i && (rd_addr_i == ADDR_W'(s));

    always_ff @(posedge clk) begin
      if (rst)
        st_q <= '0;
      else
        st_q <= (hit ? '0 : st_q) | evt_i[s*DATA_W +: DATA_W];
    end

    assign status_o[s*DATA_W +: DATA_W] = st_q;
  end

  // Read selection; addresses past the last source select zero.
  always_comb begin
    sel_data = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      if (rd_addr_i == ADDR_W'(s))
        sel_data = status_o[s*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data_o <= '0;
    else
      rd_data_o <= rd_stb_i ? sel_data : '0;
  end

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FRM_REGS = 8,
  parameter int unsigned NUM_SRC  = FRM_REGS + 2
) (
  input  logic [NUM_SRC*DATA_W-1:0] status_i,
  input  logic [NUM_SRC*DATA_W-1:0] bit_en_i,
  input  logic [NUM_GRP-1:0]        blk_en_i,
  output logic                      irq_o
);

  logic [NUM_SRC-1:0] src_act;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int unsigned GRP = grp_of(s, FRM_REGS);
    assign src_act[s] = (|(status_i[s*DATA_W +: DATA_W] & bit_en_i[s*DATA_W +: DATA_W]))
                        & blk_en_i[GRP];
  end

  assign irq_o = |src_act;

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic mode_release_i,
  input  logic mode_low_i,
  output logic pin_o,
  output logic oe_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
      oe_o  <= 1'b1;
    end else begin
      pin_o <= irq_i ^ mode_low_i;
      oe_o  <= irq_i | ~mode_release_i;
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FRM_REGS = 8,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned NUM_SRC = FRM_REGS + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC*DATA_W-1:0] evt_i,
  input  logic [NUM_SRC*DATA_W-1:0] bit_en_i,
  input  logic [2:0]                blk_en_i,
  input  logic                      mode_release_i,
  input  logic                      mode_low_i,
  input  logic                      rd_stb_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic                      irq_pin_o,
  output logic                      irq_oe_o
);

  logic [NUM_SRC*DATA_W-1:0] status_q;
  logic                      irq_raw;

  irq_status_bank #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .rd_stb_i (rd_stb_i),
    .rd_addr_i(rd_addr_i),
    .status_o (status_q),
    .rd_data_o(rd_data_o)
  );

  irq_gate #(
    .DATA_W  (DATA_W),
    .FRM_REGS(FRM_REGS),
    .NUM_SRC (NUM_SRC)
  ) u_gate (
    .status_i(status_q),
    .bit_en_i(bit_en_i),
    .blk_en_i(blk_en_i),
    .irq_o   (irq_raw)
  );

  irq_pin_ctrl u_pin (
    .clk           (clk),
    .rst           (rst),
    .irq_i         (irq_raw),
    .mode_release_i(mode_release_i),
    .mode_low_i    (mode_low_i),
    .pin_o         (irq_pin_o),
    .oe_o          (irq_oe_o)
  );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned ADDR_W  = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_SRC*DATA_W-1:0] evt_i,
  input logic [NUM_SRC*DATA_W-1:0] bit_en_i,
  input logic [2:0]                blk_en_i,
  input logic                      mode_release_i,
  input logic                      mode_low_i,
  input logic                      rd_stb_i,
  input logic [ADDR_W-1:0]         rd_addr_i,
  input logic [DATA_W-1:0]         rd_data_o,
  input logic                      irq_pin_o,
  input logic                      irq_oe_o,
  input logic [NUM_SRC*DATA_W-1:0] status_q
);

  logic                      live;
  logic [NUM_SRC*DATA_W-1:0] clr_mask;
  logic                      asserted;

  always_ff @(posedge clk) live <= !rst;

  always_comb begin
    clr_mask = '0;
    for (int unsigned s = 0; s < NUM_SRC; s++) begin
      if (rd_stb_i && (rd_addr_i == ADDR_W'(s)))
        clr_mask[s*DATA_W +: DATA_W] = '1;
    end
  end

  assign asserted = irq_oe_o && (irq_pin_o != mode_low_i);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_oe_o && !irq_pin_o && rd_data_o == '0));

  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst || !live)
    ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (rst || !live)
    ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_bad_addr_zero_R8: assert property (@(posedge clk) disable iff (rst || !live)
    $past(rd_stb_i && (rd_addr_i >= ADDR_W'(NUM_SRC))) |-> (rd_data_o == '0));

  assert_release_only_R7: assert property (@(posedge clk) disable iff (rst || !live)
    !irq_oe_o |-> ($past(mode_release_i) && irq_pin_o == $past(mode_low_i)));

  assert_gated_source_R5: assert property (@(posedge clk) disable iff (rst || !live)
    (irq_oe_o && irq_pin_o != $past(mode_low_i))
      |-> $past((|(status_q & bit_en_i)) && (|blk_en_i)));

  assert_no_read_zero_R3: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!rd_stb_i) |-> (rd_data_o == '0));

  // asserted is used only as a sanity cross-term for R6 timing
  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst || !live)
    ($stable(mode_low_i) && $past(!asserted) && $past(mode_low_i) == mode_low_i
      && irq_oe_o && irq_pin_o != mode_low_i) |-> $past(|(status_q & bit_en_i)));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .DATA_W (DATA_W),
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .evt_i         (evt_i),
  .bit_en_i      (bit_en_i),
  .blk_en_i      (blk_en_i),
  .mode_release_i(mode_release_i),
  .mode_low_i    (mode_low_i),
  .rd_stb_i      (rd_stb_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .irq_pin_o     (irq_pin_o),
  .irq_oe_o      (irq_oe_o),
  .status_q      (status_q)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int FRM_REGS   = 8;
  localparam int ADDR_W     = 4;
  localparam int NUM_SRC    = FRM_REGS + 2;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic [NUM_SRC*DATA_W-1:0] evt_i = '0;
  logic [NUM_SRC*DATA_W-1:0] bit_en_i = '0;
  logic [2:0]                blk_en_i = '0;
  logic                      mode_release_i = 1'b0;
  logic                      mode_low_i = 1'b0;
  logic                      rd_stb_i = 1'b0;
  logic [ADDR_W-1:0]         rd_addr_i = '0;
  logic [DATA_W-1:0]         rd_data_o;
  logic                      irq_pin_o;
  logic                      irq_oe_o;

  irq_aggregator #(
    .DATA_W  (DATA_W),
    .FRM_REGS(FRM_REGS),
    .ADDR_W  (ADDR_W)
  ) i_irq_aggregator (
    .clk           (clk),
    .rst           (rst),
    .evt_i         (evt_i),
    .bit_en_i      (bit_en_i),
    .blk_en_i      (blk_en_i),
    .mode_release_i(mode_release_i),
    .mode_low_i    (mode_low_i),
    .rd_stb_i      (rd_stb_i),
    .rd_addr_i     (rd_addr_i),
    .rd_data_o     (rd_data_o),
    .irq_pin_o     (irq_pin_o),
    .irq_oe_o      (irq_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    cmp_en = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, updated on each rising edge.
  logic [DATA_W-1:0] m_st [NUM_SRC];
  logic              m_pin = 1'b0;
  logic              m_oe  = 1'b1;
  logic [DATA_W-1:0] m_rd  = '0;
  logic              m_irq;

  function automatic int grp_index(input int s);
    if (s == 0) return 0;
    if (s <= FRM_REGS) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) m_st[s] = '0;
      m_pin = 1'b0;
      m_oe  = 1'b1;
      m_rd  = '0;
    end else begin
      m_irq = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        if (((m_st[s] & bit_en_i[s*DATA_W +: DATA_W]) != 0) && blk_en_i[grp_index(s)])
          m_irq = 1'b1;
      m_pin = m_irq ^ mode_low_i;
      m_oe  = m_irq | !mode_release_i;
      m_rd  = (rd_stb_i && int'(rd_addr_i) < NUM_SRC) ? m_st[rd_addr_i] : '0;
      for (int s = 0; s < NUM_SRC; s++)
        m_st[s] = ((rd_stb_i && int'(rd_addr_i) == s) ? '0 : m_st[s])
                  | evt_i[s*DATA_W +: DATA_W];
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check(irq_pin_o == m_pin, phase, "pin", int'(irq_pin_o), int'(m_pin));
      check(irq_oe_o == m_oe, phase, "oe", int'(irq_oe_o), int'(m_oe));
      check(rd_data_o == m_rd, phase, "rd_data", int'(rd_data_o), int'(m_rd));
    end
  end

  task automatic pulse_evt(input int s, input logic [DATA_W-1:0] v);
    evt_i[s*DATA_W +: DATA_W] = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic do_read(input int a, output logic [DATA_W-1:0] d);
    rd_stb_i  = 1'b1;
    rd_addr_i = ADDR_W'(a);
    @(negedge clk);
    rd_stb_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] d;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    phase = "R1";
    check(irq_pin_o == 1'b0 && irq_oe_o == 1'b1, "R1", "pin/oe after reset",
          {irq_pin_o, irq_oe_o}, 2'b01);
    check(rd_data_o == 0, "R1", "rd_data after reset", rd_data_o, 0);
    do_read(7, d);
    check(d == 0, "R1", "status after reset", d, 0);

    phase = "R2";
    pulse_evt(3, 8'h5A);
    pulse_evt(3, 8'h00);
    repeat (4) @(negedge clk);
    do_read(3, d);
    check(d == 8'h5A, "R2", "sticky status", d, 8'h5A);

    phase = "R3";
    do_read(3, d);
    check(d == 8'h00, "R3", "cleared by read", d, 0);
    pulse_evt(9, 8'h81);
    pulse_evt(4, 8'h0F);
    do_read(9, d);
    check(d == 8'h81, "R3", "read src 9", d, 8'h81);
    do_read(4, d);
    check(d == 8'h0F, "R3", "other register untouched", d, 8'h0F);

    phase = "R4";
    pulse_evt(5, 8'h01);
    evt_i[5*DATA_W +: DATA_W] = 8'h10;
    do_read(5, d);
    evt_i = '0;
    check(d == 8'h01, "R4", "pre-read value", d, 8'h01);
    do_read(5, d);
    check(d == 8'h10, "R4", "event beats clear", d, 8'h10);

    phase = "R8";
    pulse_evt(0, 8'hFF);
    do_read(12, d);
    check(d == 8'h00, "R8", "out of range read", d, 0);
    do_read(0, d);
    check(d == 8'hFF, "R8", "no clear on bad address", d, 8'hFF);

    phase = "R5";
    bit_en_i[2*DATA_W +: DATA_W] = 8'h02;
    pulse_evt(2, 8'h02);
    @(negedge clk);
    check(irq_pin_o == 1'b0, "R5", "group disabled", irq_pin_o, 0);
    blk_en_i = 3'b010;
    @(negedge clk);
    check(irq_pin_o == 1'b1, "R6", "asserts one cycle after enable", irq_pin_o, 1);
    do_read(2, d);
    check(irq_pin_o == 1'b1, "R6", "pin still high at read return", irq_pin_o, 1);
    @(negedge clk);
    check(irq_pin_o == 1'b0, "R3", "read drops interrupt", irq_pin_o, 0);
    bit_en_i[9*DATA_W +: DATA_W] = 8'hFF;
    blk_en_i = 3'b011;
    pulse_evt(9, 8'h01);
    @(negedge clk);
    check(irq_pin_o == 1'b0, "R5", "link source needs group 2", irq_pin_o, 0);
    blk_en_i = 3'b100;
    @(negedge clk);
    check(irq_pin_o == 1'b1, "R5", "link source with group 2", irq_pin_o, 1);
    do_read(9, d);
    bit_en_i = '0;

    phase = "R7";
    bit_en_i[1*DATA_W +: DATA_W] = 8'h01;
    blk_en_i = 3'b111;
    pulse_evt(1, 8'h01);
    for (int m = 0; m < 4; m++) begin
      mode_release_i = m[0];
      mode_low_i     = m[1];
      @(negedge clk);
      check(irq_pin_o == !m[1] && irq_oe_o, "R7", "asserted pin/oe",
            {irq_pin_o, irq_oe_o}, {!m[1], 1'b1});
    end
    do_read(1, d);
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      mode_release_i = m[0];
      mode_low_i     = m[1];
      @(negedge clk);
      check(irq_pin_o == m[1] && irq_oe_o == !m[0], "R7", "idle pin/oe",
            {irq_pin_o, irq_oe_o}, {m[1], !m[0]});
    end

    phase = "R6";
    for (int c = 0; c < 4000; c++) begin
      evt_i = '0;
      for (int s = 0; s < NUM_SRC; s++)
        if ($urandom_range(7) == 0) evt_i[s*DATA_W +: DATA_W] = DATA_W'($urandom);
      if ($urandom_range(15) == 0) bit_en_i = {$urandom, $urandom, $urandom};
      if ($urandom_range(15) == 0) blk_en_i = 3'($urandom);
      if ($urandom_range(31) == 0) begin
        mode_release_i = 1'($urandom);
        mode_low_i     = 1'($urandom);
      end
      rd_stb_i  = ($urandom_range(2) == 0);
      rd_addr_i = ADDR_W'($urandom);
      @(negedge clk);
    end
    evt_i = '0;
    rd_stb_i = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule